// File: doc/BRIEF.md
# Parallel-Sample Edge Trigger Detector

This block watches a wide sample stream in which every accepted beat carries a whole block of ADC samples at once: by default 40 samples of 12 bits, gathered from 4 interleaved lanes with 10 samples per lane. It looks for the moment the signal passes a programmable threshold, going up or going down. It also accepts an asynchronous external trigger. Once the block is armed, the first such event makes it emit a one-cycle trigger pulse. It records which sample slot of the beat held the crossing, and it latches the capture buffer's write address from that same cycle. It then raises a frozen flag, which tells the capture logic to stop writing. The block keeps that result until it is armed again after readout.

Slot i of the beat sits at bits [i*12 +: 12] and belongs to lane i mod 4. The slot order is time order, so slot 0 is the oldest sample and a slot's predecessor is the slot before it. The last slots of the previous accepted beat are kept, so a crossing that spans two beats is found at the first slot of the new beat. In dual-channel mode, lanes 0 and 1 carry channel 0 and lanes 2 and 3 carry channel 1. Only the selected channel's 20 slots are searched, each compared with that channel's own previous sample.

The sample input is a stream with a valid qualifier and no back-pressure. The block accepts every beat on which `s_valid` is high and never stalls the source, so it has no ready output. Beats with `s_valid` low are skipped completely. Control and status pins are plain levels or pulses.

Top module: `ptrig_edge_detect`

## Requirements
- R1: After reset, `trig_pulse`, `frozen`, `trig_slot` and `trig_addr` are all 0, and the block is not armed.
- R2: Rising mode (`trig_mode`=0): slot i crosses when its predecessor is below `thresh` and slot i is greater than or equal to `thresh`. A sample equal to the threshold counts as at or above it.
- R3: Falling mode (`trig_mode`=1): slot i crosses when its predecessor is at or above `thresh` and slot i is below it.
- R4: The predecessor of slot 0 in single-channel mode is slot 39 of the previous accepted beat. No crossing through this predecessor is reported before the first accepted beat after reset.
- R5: When several slots cross in the same beat, `trig_slot` reports the lowest slot index.
- R6: With `dual_mode`=1, only slots whose lane (i mod 4) belongs to the channel picked by `chan_sel` are searched: lanes 0–1 for channel 0, lanes 2–3 for channel 1. A lane-0 or lane-2 slot takes its predecessor from the channel's second lane in the previous row, or from the previous beat for the first row. Crossings in the other channel are ignored.
- R7: External mode (`trig_mode`=2): `ext_trig` passes through a two-flop synchronizer, and a rising edge fires the trigger. `trig_pulse` goes high after the third rising clock edge that follows the input change, and `trig_slot` is 0.
- R8: Crossings and external edges are ignored while the block is not armed. Mode 3 never fires.
- R9: `trig_pulse` goes high for exactly one cycle, in the cycle after the edge that accepted the crossing beat. `trig_addr` then holds the `wr_addr` value sampled at that edge.
- R10: After a trigger, `frozen` stays high and `trig_slot`/`trig_addr` stay unchanged, whatever the sample data, until `arm` is pulsed. `arm` clears `frozen` and re-arms the block, and a crossing in the same cycle as `arm` is ignored.
- R11: A beat with `s_valid` low is neither searched nor stored as the predecessor for the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample beat qualifier |
| s_data | input | 480 | 40 samples, slot i at [i*12 +: 12] |
| thresh | input | 12 | Trigger threshold |
| trig_mode | input | 2 | 0 rising, 1 falling, 2 external, 3 off |
| dual_mode | input | 1 | 1 = two channels of two lanes each |
| chan_sel | input | 1 | Channel searched in dual mode |
| arm | input | 1 | One-cycle pulse: re-arm and clear frozen |
| ext_trig | input | 1 | Asynchronous external trigger |
| wr_addr | input | 10 | Current capture buffer write address |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_slot | output | 6 | Slot index of the crossing |
| trig_addr | output | 10 | Latched write address |
| frozen | output | 1 | Triggered; capture writing must stop |

## Verification
Some properties are checked by the assertions on every cycle. The trigger pulse lasts a single cycle and always comes with the frozen flag. The latched address equals the write address one cycle earlier. An external trigger reports slot 0. Frozen can only rise out of the armed state, and a frozen result stays unchanged until re-arm. The other behaviours can only be shown by the bench's scenarios. These are the slot chosen for every step position in both polarities and both dual-channel selections, the equality-at-threshold case, the carry across a beat boundary, the lowest-slot priority, the skipping of invalid beats and the synchronizer latency.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;
  typedef enum logic [1:0] {
    TM_RISE = 2'd0,
    TM_FALL = 2'd1,
    TM_EXT  = 2'd2,
    TM_OFF  = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_FROZEN = 2'd2
  } trig_state_e;
endpackage

// File: rtl/ptrig_ext_sync.sv
module ptrig_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], async_in};
  end

  // edge taken between last sync stage and one extra history flop
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ptrig_slot_scan.sv
module ptrig_slot_scan #(
  parameter int LANES = 4,
  parameter int SPL   = 10,
  parameter int SW    = 12,
  localparam int NSLOT = LANES * SPL,
  localparam int HALF  = LANES / 2
) (
  input  logic [NSLOT*SW-1:0]     beat,
  input  logic [LANES-1:0][SW-1:0] tail,
  input  logic                    hist_ok,
  input  logic [SW-1:0]           thresh,
  input  logic                    falling,
  input  logic                    dual,
  input  logic                    chan_sel,
  output logic [NSLOT-1:0]        hit
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int L = i % LANES;
    localparam int G = L / HALF;
    localparam int Q = L % HALF;

    logic [SW-1:0] pred_s, pred_d, pred, cur;
    logic          tail_s, tail_d, use_tail;
    logic          up_cur, up_pred, edge_ok, in_chan;

    if (i == 0) begin : g_s0
      assign pred_s = tail[LANES-1];
      assign tail_s = 1'b1;
    end else begin : g_sn
      assign pred_s = beat[(i-1)*SW +: SW];
      assign tail_s = 1'b0;
    end

    if (Q != 0) begin : g_dq
      assign pred_d = beat[(i-1)*SW +: SW];
      assign tail_d = 1'b0;
    end else if (i >= LANES) begin : g_drow
      assign pred_d = beat[(i-LANES+HALF-1)*SW +: SW];
      assign tail_d = 1'b0;
    end else begin : g_dtail
      assign pred_d = tail[G*HALF+HALF-1];
      assign tail_d = 1'b1;
    end

    assign cur      = beat[i*SW +: SW];
    assign pred     = dual ? pred_d : pred_s;
    assign use_tail = dual ? tail_d : tail_s;
    assign up_cur   = (cur  >= thresh);
    assign up_pred  = (pred >= thresh);
    assign edge_ok  = falling ? (up_pred & ~up_cur) : (~up_pred & up_cur);
    assign in_chan  = ~dual | (chan_sel == 1'(G));
    assign hit[i]   = edge_ok & in_chan & (~use_tail | hist_ok);
  end
endmodule

// File: rtl/ptrig_prio_enc.sv
module ptrig_prio_enc #(
  parameter int N  = 40,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ptrig_edge_detect.sv
module ptrig_edge_detect
  import ptrig_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SPL   = 10,
  parameter int SW    = 12,
  parameter int AW    = 10,
  localparam int NSLOT = LANES * SPL,
  localparam int IW    = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [NSLOT*SW-1:0] s_data,
  input  logic [SW-1:0]       thresh,
  input  logic [1:0]          trig_mode,
  input  logic                dual_mode,
  input  logic                chan_sel,
  input  logic                arm,
  input  logic                ext_trig,
  input  logic [AW-1:0]       wr_addr,
  output logic                trig_pulse,
  output logic [IW-1:0]       trig_slot,
  output logic [AW-1:0]       trig_addr,
  output logic                frozen
);
  trig_mode_e                mode;
  trig_state_e               state_q;
  logic [LANES-1:0][SW-1:0]  tail_q;
  logic                      hist_q;
  logic [NSLOT-1:0]          hit;
  logic                      hit_any;
  logic [IW-1:0]             hit_idx;
  logic                      ext_rise;
  logic                      fire;

  assign mode = trig_mode_e'(trig_mode);

  ptrig_ext_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trig), .rise_o(ext_rise)
  );

  ptrig_slot_scan #(.LANES(LANES), .SPL(SPL), .SW(SW)) u_scan (
    .beat(s_data), .tail(tail_q), .hist_ok(hist_q), .thresh(thresh),
    .falling(mode == TM_FALL), .dual(dual_mode), .chan_sel(chan_sel),
    .hit(hit)
  );

  ptrig_prio_enc #(.N(NSLOT)) u_enc (
    .req(hit), .any(hit_any), .idx(hit_idx)
  );

  // history of the last row of every accepted beat
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
      hist_q <= 1'b0;
    end else if (s_valid) begin
      for (int l = 0; l < LANES; l++)
        tail_q[l] <= s_data[(NSLOT-LANES+l)*SW +: SW];
      hist_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      TM_EXT:  fire = ext_rise;
      TM_OFF:  fire = 1'b0;
      default: fire = s_valid & hit_any;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      trig_pulse <= 1'b0;
      trig_slot  <= '0;
      trig_addr  <= '0;
    end else if (arm) begin
      state_q    <= ST_ARMED;
      trig_pulse <= 1'b0;
    end else if (state_q == ST_ARMED && fire) begin
      state_q    <= ST_FROZEN;
      trig_pulse <= 1'b1;
      trig_slot  <= (mode == TM_EXT) ? '0 : hit_idx;
      trig_addr  <= wr_addr;
    end else begin
      trig_pulse <= 1'b0;
    end
  end

  assign frozen = (state_q == ST_FROZEN);

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
  p_addr_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> trig_addr == $past(wr_addr));
  p_pulse_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> frozen);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !arm) |=> (frozen && $stable(trig_addr) && $stable(trig_slot)));
  p_armed_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(state_q == ST_ARMED && !arm));
  p_ext_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(mode == TM_EXT)) |-> trig_slot == '0);
  p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> trig_slot < IW'(NSLOT));
endmodule

// File: tb/ptrig_edge_detect_tb_top.sv
module ptrig_edge_detect_tb_top;
  localparam int LANES = 4, SPL = 10, SW = 12, AW = 10;
  localparam int NSLOT = LANES * SPL;
  localparam logic [SW-1:0] THR = 12'd2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [NSLOT*SW-1:0] s_data = '0;
  logic [SW-1:0] thresh = THR;
  logic [1:0] trig_mode = 2'd0;
  logic dual_mode = 1'b0, chan_sel = 1'b0, arm = 1'b0, ext_trig = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic trig_pulse, frozen;
  logic [5:0] trig_slot;
  logic [AW-1:0] trig_addr;

  int n_chk = 0, n_err = 0, n_case = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptrig_edge_detect #(.LANES(LANES), .SPL(SPL), .SW(SW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .thresh(thresh), .trig_mode(trig_mode), .dual_mode(dual_mode),
    .chan_sel(chan_sel), .arm(arm), .ext_trig(ext_trig), .wr_addr(wr_addr),
    .trig_pulse(trig_pulse), .trig_slot(trig_slot), .trig_addr(trig_addr),
    .frozen(frozen)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] hi_val(input int k);
    return (k % 2 == 0) ? THR : THR + 12'd37;
  endfunction

  // single mode step: slots >= p on the far side of the threshold
  function automatic logic [NSLOT*SW-1:0] step_beat(input int p, input bit fall);
    logic [NSLOT*SW-1:0] d;
    for (int i = 0; i < NSLOT; i++) begin
      logic up;
      up = (i >= p) ^ fall;
      d[i*SW +: SW] = up ? hi_val(i) : THR - 12'd1;
    end
    return d;
  endfunction

  // dual mode: channel c stepped at channel position k, other channel noisy
  function automatic logic [NSLOT*SW-1:0] dual_beat(input int c, input int k, input bit fall);
    logic [NSLOT*SW-1:0] d;
    for (int i = 0; i < NSLOT; i++) begin
      int lane, g, pos;
      logic up;
      lane = i % LANES; g = lane / 2; pos = (i / LANES) * 2 + lane % 2;
      if (g == c) up = (pos >= k) ^ fall;
      else        up = (i % 2 == 1);
      d[i*SW +: SW] = up ? hi_val(i) : THR - 12'd1;
    end
    return d;
  endfunction

  task automatic do_arm();
    @(negedge clk); arm = 1'b1; s_valid = 1'b0;
    @(negedge clk); arm = 1'b0;
  endtask

  // base beat, then stepped beat; expect trigger at slot exp_slot
  task automatic run_case(input logic [NSLOT*SW-1:0] base, input logic [NSLOT*SW-1:0] stp,
                          input int exp_slot, input string tag);
    logic [AW-1:0] a;
    n_case++;
    a = AW'(n_case * 7 + 3);
    do_arm();
    s_valid = 1'b1; s_data = base; wr_addr = a + 1'b1;
    @(negedge clk);
    chk(trig_pulse == 1'b0 && frozen == 1'b0, {tag, " quiet base"}, int'(trig_pulse), 0);
    s_data = stp; wr_addr = a;
    @(negedge clk);
    s_valid = 1'b0; wr_addr = a + 2'd2;
    chk(trig_pulse == 1'b1, {tag, " pulse R9"}, int'(trig_pulse), 1);
    chk(int'(trig_slot) == exp_slot, {tag, " slot"}, int'(trig_slot), exp_slot);
    chk(trig_addr == a, {tag, " addr R9"}, int'(trig_addr), int'(a));
    @(negedge clk);
    chk(trig_pulse == 1'b0 && frozen == 1'b1, {tag, " one-cycle R9 R10"}, int'(trig_pulse), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(trig_pulse == 0 && frozen == 0 && trig_slot == 0 && trig_addr == 0,
        "R1 reset outputs", int'(frozen), 0);
    rst_n = 1'b1;

    // R8 unarmed: a crossing beat does nothing
    @(negedge clk); s_valid = 1'b1; s_data = step_beat(5, 1'b0);
    @(negedge clk); s_valid = 1'b0;
    @(negedge clk);
    chk(trig_pulse == 0 && frozen == 0, "R8 unarmed ignored", int'(frozen), 0);

    // R4 no boundary compare before first accepted beat since reset
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_arm();
    s_valid = 1'b1; s_data = step_beat(0, 1'b0);
    @(negedge clk); s_valid = 1'b0;
    @(negedge clk);
    chk(trig_pulse == 0 && frozen == 0, "R4 no history after reset", int'(frozen), 0);

    // R2/R3/R4 sweep every slot in single mode, both polarities
    for (int p = 0; p < NSLOT; p++)
      run_case(step_beat(NSLOT, 1'b0), step_beat(p, 1'b0), p, $sformatf("R2 rise p=%0d", p));
    trig_mode = 2'd1;
    for (int p = 0; p < NSLOT; p++)
      run_case(step_beat(NSLOT, 1'b1), step_beat(p, 1'b1), p, $sformatf("R3 fall p=%0d", p));

    // R5 lowest slot wins
    trig_mode = 2'd0;
    begin
      logic [NSLOT*SW-1:0] d;
      for (int i = 0; i < NSLOT; i++) d[i*SW +: SW] = (i % 2) ? THR : THR - 12'd1;
      run_case(step_beat(NSLOT, 1'b0), d, 1, "R5 alternating");
      for (int i = 0; i < NSLOT; i++)
        d[i*SW +: SW] = ((i >= 17 && i < 26) || i >= 30) ? THR + 12'd5 : THR - 12'd1;
      run_case(step_beat(NSLOT, 1'b0), d, 17, "R5 two crossings");
    end

    // R6 dual mode sweep, both channels and polarities
    dual_mode = 1'b1;
    for (int f = 0; f < 2; f++) begin
      trig_mode = 2'(f);
      for (int c = 0; c < 2; c++) begin
        chan_sel = 1'(c);
        for (int k = 0; k < 20; k++)
          run_case(dual_beat(c, 20, f[0]), dual_beat(c, k, f[0]),
                   (k / 2) * 4 + 2 * c + (k % 2), $sformatf("R6 ch%0d k=%0d f=%0d", c, k, f));
      end
    end
    dual_mode = 1'b0; chan_sel = 1'b0; trig_mode = 2'd0;

    // R10 frozen ignores further crossings and holds outputs
    begin
      int hs, ha;
      hs = int'(trig_slot); ha = int'(trig_addr);
      @(negedge clk); s_valid = 1'b1; s_data = step_beat(NSLOT, 1'b0); wr_addr = 10'd999;
      @(negedge clk); s_data = step_beat(3, 1'b0);
      @(negedge clk); s_valid = 1'b0;
      chk(trig_pulse == 0 && frozen == 1, "R10 frozen no pulse", int'(trig_pulse), 0);
      chk(int'(trig_slot) == hs && int'(trig_addr) == ha, "R10 hold addr", int'(trig_addr), ha);
    end

    // R10 crossing in the arm cycle ignored
    @(negedge clk); s_valid = 1'b1; s_data = step_beat(NSLOT, 1'b0);
    @(negedge clk); arm = 1'b1; s_data = step_beat(4, 1'b0);
    @(negedge clk); arm = 1'b0; s_valid = 1'b0;
    chk(frozen == 0 && trig_pulse == 0, "R10 arm clears, same-cycle crossing ignored", int'(frozen), 0);

    // R11 invalid beat neither searched nor stored
    @(negedge clk); s_valid = 1'b1; s_data = step_beat(NSLOT, 1'b0);
    @(negedge clk); s_valid = 1'b0; s_data = step_beat(0, 1'b0);
    @(negedge clk);
    chk(trig_pulse == 0 && frozen == 0, "R11 invalid beat ignored", int'(trig_pulse), 0);
    s_valid = 1'b1; s_data = step_beat(0, 1'b0);
    @(negedge clk); s_valid = 1'b0;
    chk(trig_pulse == 1 && trig_slot == 0, "R11 history kept from valid beat", int'(trig_slot), 0);

    // R8 mode 3 never fires
    trig_mode = 2'd3;
    do_arm();
    s_valid = 1'b1; s_data = step_beat(NSLOT, 1'b0);
    @(negedge clk); s_data = step_beat(9, 1'b0);
    @(negedge clk); s_valid = 1'b0;
    @(negedge clk);
    chk(trig_pulse == 0 && frozen == 0, "R8 mode off", int'(frozen), 0);

    // R7 external trigger latency and slot 0
    trig_mode = 2'd2;
    do_arm();
    wr_addr = 10'd100; s_valid = 1'b1; s_data = step_beat(7, 1'b0);
    ext_trig = 1'b1;
    @(negedge clk);
    chk(trig_pulse == 0, "R7 ext edge 1", int'(trig_pulse), 0);
    wr_addr = 10'd101;
    @(negedge clk);
    chk(trig_pulse == 0, "R7 ext edge 2", int'(trig_pulse), 0);
    wr_addr = 10'd102;
    @(negedge clk);
    chk(trig_pulse == 1 && trig_slot == 0, "R7 ext pulse slot0", int'(trig_slot), 0);
    chk(trig_addr == 10'd102, "R7 ext addr", int'(trig_addr), 102);
    @(negedge clk);
    chk(trig_pulse == 0 && frozen == 1, "R7 ext single pulse", int'(trig_pulse), 0);
    ext_trig = 1'b0; s_valid = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule